// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter that works on a block of three samples in each clock. Three consecutive samples arrive together on lanes 0, 1 and 2, marked by one shared valid flag. Lane 0 holds the oldest sample of the block and lane 2 the newest. Three results leave on output lanes in the same order. The filter therefore handles three samples per clock, so the effective sample period is one third of the clock period. Each lane's combinational path is still one multiplier followed by two adders, which is the same path as in a one-sample-per-clock filter.

Some taps of the early lanes need samples from the previous block. Two carry registers keep the two newest samples of each accepted block, and these take the place of x(3k−2) and x(3k−1) in the next block. The three coefficients are plain inputs. They are used in the same cycle that a valid block is accepted. The results are registered, so the latency is one cycle.

There is no control state machine. The only sequential state is the two-sample carry and the output register bank. Both update only when a block is accepted.

Top module: `fir3p_block`

## Requirements
- R1: Output lane 0 equals a·x(3k) + b·x(3k−1) + c·x(3k−2), where x(3k) is input lane 0 of the block.
- R2: Output lane 1 equals a·x(3k+1) + b·x(3k) + c·x(3k−1), where x(3k+1) is input lane 1.
- R3: Output lane 2 equals a·x(3k+2) + b·x(3k+1) + c·x(3k), where x(3k+2) is input lane 2.
- R4: `out_valid` is high in the cycle after `in_valid` is high, and low in the cycle after `in_valid` is low. The latency is one clock.
- R5: The carry registers load input lanes 1 and 2 only when `in_valid` is high. Samples presented while `in_valid` is low have no effect on later results.
- R6: While `rst_n` is low, `out_valid` is 0, all outputs are 0 and the carry is 0. The first block after reset therefore treats x(−1) and x(−2) as zero.
- R7: While no block is accepted, all three outputs keep their last values.
- R8: Samples and coefficients are 16-bit two's complement. Outputs are 34-bit two's complement at full precision, with no wrap at the extreme values.
- R9: The coefficients in force are the ones present in the cycle that the block is accepted. A coefficient change takes effect on the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The three input lanes carry a block |
| x_l0 | input | 16 | Oldest sample of the block, x(3k) |
| x_l1 | input | 16 | Middle sample, x(3k+1) |
| x_l2 | input | 16 | Newest sample, x(3k+2) |
| coef_a | input | 16 | Weight of the current sample |
| coef_b | input | 16 | Weight of the sample one step older |
| coef_c | input | 16 | Weight of the sample two steps older |
| out_valid | output | 1 | The output lanes hold a new block |
| y_l0 | output | 34 | Result y(3k) |
| y_l1 | output | 34 | Result y(3k+1) |
| y_l2 | output | 34 | Result y(3k+2) |

## Verification
The assertions assume that `in_valid` is a clean, defined level at every rising edge once reset is released, and that reset is held for at least one edge. The stability properties rely on this.

The bench drives all inputs only on falling edges and always with defined values. During idle cycles it supplies deliberate junk samples, so that the hold properties and R5 are exercised by real data and not by X values.

Expected results come from a serial, one-sample-at-a-time reference that keeps its own two-sample history. That history runs across gaps and across coefficient changes.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
    // Lane and tap structure of the block filter.
    localparam int LANES = 3;
    localparam int TAPS  = 3;
    // Samples visible to the lanes: current block plus carried history.
    localparam int WIN   = LANES + TAPS - 1;
    localparam int CARRY = TAPS - 1;
endpackage

// File: rtl/fir3p_lane.sv
// One output lane: three products and two additions at full precision.
module fir3p_lane #(
    parameter int SW = 16,
    parameter int CW = 16,
    parameter int OW = SW + CW + 2
) (
    input  logic signed [SW-1:0] x_cur,
    input  logic signed [SW-1:0] x_d1,
    input  logic signed [SW-1:0] x_d2,
    input  logic signed [CW-1:0] k_a,
    input  logic signed [CW-1:0] k_b,
    input  logic signed [CW-1:0] k_c,
    output logic signed [OW-1:0] y
);
    logic signed [OW-1:0] p_a, p_b, p_c;

    always_comb begin
        p_a = OW'(x_cur) * OW'(k_a);
        p_b = OW'(x_d1)  * OW'(k_b);
        p_c = OW'(x_d2)  * OW'(k_c);
        y   = p_a + p_b + p_c;
    end
endmodule

// File: rtl/fir3p_history.sv
// Two-sample carry between blocks; loads only on an accepted block.
module fir3p_history #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [SW-1:0] x_mid,
    input  logic signed [SW-1:0] x_new,
    output logic signed [SW-1:0] h_d2,
    output logic signed [SW-1:0] h_d1
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_d2 <= '0;
            h_d1 <= '0;
        end else if (load) begin
            h_d2 <= x_mid;
            h_d1 <= x_new;
        end
    end

    // R5: carry is untouched without a valid block
    p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(h_d1) && $stable(h_d2)));

    // R5: carry captures the two newest samples of an accepted block
    p_hist_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (h_d1 == $past(x_new) && h_d2 == $past(x_mid)));
endmodule

// File: rtl/fir3p_block.sv
// Three-parallel block FIR filter, registered outputs.
module fir3p_block #(
    parameter int SW = 16,
    parameter int CW = 16,
    parameter int OW = SW + CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] x_l0,
    input  logic signed [SW-1:0] x_l1,
    input  logic signed [SW-1:0] x_l2,
    input  logic signed [CW-1:0] coef_a,
    input  logic signed [CW-1:0] coef_b,
    input  logic signed [CW-1:0] coef_c,
    output logic                 out_valid,
    output logic signed [OW-1:0] y_l0,
    output logic signed [OW-1:0] y_l1,
    output logic signed [OW-1:0] y_l2
);
    import fir3p_pkg::*;

    logic signed [SW-1:0] h_d2, h_d1;
    logic signed [SW-1:0] win   [WIN];
    logic signed [OW-1:0] y_nxt [LANES];
    logic signed [OW-1:0] y_q   [LANES];

    fir3p_history #(.SW(SW)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .x_mid (x_l1),
        .x_new (x_l2),
        .h_d2  (h_d2),
        .h_d1  (h_d1)
    );

    // Window: oldest carried sample first, newest block sample last.
    always_comb begin
        win[0] = h_d2;
        win[1] = h_d1;
        win[2] = x_l0;
        win[3] = x_l1;
        win[4] = x_l2;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fir3p_lane #(.SW(SW), .CW(CW), .OW(OW)) u_lane (
            .x_cur (win[g + CARRY]),
            .x_d1  (win[g + CARRY - 1]),
            .x_d2  (win[g]),
            .k_a   (coef_a),
            .k_b   (coef_b),
            .k_c   (coef_c),
            .y     (y_nxt[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        y_q[g] <= '0;
            else if (in_valid) y_q[g] <= y_nxt[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    assign y_l0 = y_q[0];
    assign y_l1 = y_q[1];
    assign y_l2 = y_q[2];

    // R4: one-cycle latency of the valid flag
    p_valid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: results hold while nothing is accepted
    p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_l0) && $stable(y_l1) && $stable(y_l2)));

    // R6: valid flag stays low while reset is active
    always_comb begin
        if (!rst_n) p_reset_quiet_r6: assert (out_valid == 1'b0);
    end
endmodule

// File: tb/tb_fir3p_block.sv
module tb_fir3p_block;
    localparam int CLK_NS = 10;
    localparam int SW = 16;
    localparam int CW = 16;
    localparam int OW = SW + CW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] x_l0 = '0, x_l1 = '0, x_l2 = '0;
    logic signed [CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
    logic out_valid;
    logic signed [OW-1:0] y_l0, y_l1, y_l2;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // serial reference history and last expected outputs
    longint r_h1 = 0, r_h2 = 0;
    longint e0 = 0, e1 = 0, e2 = 0;

    always #(CLK_NS/2) clk = ~clk;

    fir3p_block #(.SW(SW), .CW(CW), .OW(OW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_l0(x_l0), .x_l1(x_l1), .x_l2(x_l2),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .y_l0(y_l0), .y_l1(y_l1), .y_l2(y_l2)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one sample through the serial reference filter
    function automatic longint ref_step(input longint x);
        longint y;
        y = longint'(coef_a) * x + longint'(coef_b) * r_h1 + longint'(coef_c) * r_h2;
        r_h2 = r_h1;
        r_h1 = x;
        return y;
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic send_block(input string tag, input logic signed [SW-1:0] a0,
                              input logic signed [SW-1:0] a1, input logic signed [SW-1:0] a2);
        in_valid = 1'b1;
        x_l0 = a0; x_l1 = a1; x_l2 = a2;
        e0 = ref_step(longint'(a0));
        e1 = ref_step(longint'(a1));
        e2 = ref_step(longint'(a2));
        @(negedge clk);
        check({tag, " R4 out_valid"}, longint'(out_valid), 1);
        check({tag, " R1 lane0"}, longint'(y_l0), e0);
        check({tag, " R2 lane1"}, longint'(y_l1), e1);
        check({tag, " R3 lane2"}, longint'(y_l2), e2);
    endtask

    task automatic send_idle(input string tag, input logic signed [SW-1:0] junk);
        in_valid = 1'b0;
        x_l0 = junk; x_l1 = ~junk; x_l2 = junk ^ 16'h5a5a;
        @(negedge clk);
        check({tag, " R4 idle out_valid"}, longint'(out_valid), 0);
        check({tag, " R7 hold lane0"}, longint'(y_l0), e0);
        check({tag, " R7 hold lane1"}, longint'(y_l1), e1);
        check({tag, " R7 hold lane2"}, longint'(y_l2), e2);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b0;
        r_h1 = 0; r_h2 = 0; e0 = 0; e1 = 0; e2 = 0;
        repeat (2) @(negedge clk);
        check("R6 out_valid in reset", longint'(out_valid), 0);
        check("R6 lane0 in reset", longint'(y_l0), 0);
        check("R6 lane2 in reset", longint'(y_l2), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // impulse: outputs trace out the coefficients; zero carry after reset
    task automatic t_impulse;
        coef_a = 16'sd3; coef_b = -16'sd5; coef_c = 16'sd7;
        send_block("impulse R6", 16'sd1, 16'sd0, 16'sd0);
        send_block("impulse", 16'sd0, 16'sd0, 16'sd0);
        send_block("impulse tail R5", 16'sd0, 16'sd1, 16'sd0);
        send_block("impulse tail", 16'sd0, 16'sd0, 16'sd0);
    endtask

    // random stream, back to back
    task automatic t_stream;
        coef_a = 16'sd1234; coef_b = -16'sd4321; coef_c = 16'sd999;
        for (int i = 0; i < 40; i++)
            send_block("stream", SW'($urandom), SW'($urandom), SW'($urandom));
    endtask

    // gaps with junk data must not disturb the carry
    task automatic t_gaps;
        for (int i = 0; i < 20; i++) begin
            send_block("gap R5", SW'($urandom), SW'($urandom), SW'($urandom));
            for (int j = 0; j <= i % 3; j++) send_idle("gap", SW'($urandom));
        end
    endtask

    // coefficient changes between blocks
    task automatic t_coef_swap;
        for (int i = 0; i < 15; i++) begin
            coef_a = CW'($urandom); coef_b = CW'($urandom); coef_c = CW'($urandom);
            send_block("coef R9", SW'($urandom), SW'($urandom), SW'($urandom));
        end
    endtask

    // extremes for full precision
    task automatic t_extremes;
        coef_a = -16'sd32768; coef_b = -16'sd32768; coef_c = -16'sd32768;
        send_block("extreme R8", -16'sd32768, -16'sd32768, -16'sd32768);
        send_block("extreme R8", -16'sd32768, -16'sd32768, -16'sd32768);
        coef_a = 16'sd32767; coef_b = -16'sd32768; coef_c = 16'sd32767;
        send_block("extreme mix R8", 16'sd32767, -16'sd32768, 16'sd32767);
        send_block("extreme mix R8", -16'sd32768, 16'sd32767, -16'sd32768);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_impulse();
        t_stream();
        t_gaps();
        t_coef_swap();
        t_extremes();
        send_idle("final", 16'sh1357);
        t_reset();
        coef_a = 16'sd11; coef_b = 16'sd13; coef_c = 16'sd17;
        send_block("after reset R6", 16'sd100, -16'sd200, 16'sd300);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule